// File: doc/BRIEF.md
# Shared Transmit/Receive Buffer Descriptor Ring Controller

This block owns a table of 128 buffer descriptors that software and a network frame datapath use to exchange frames. Every descriptor occupies two 32-bit words: a control word carrying a 16-bit length in its upper half and ownership and option flags in its lower half, followed by a word holding a buffer address. A movable split point divides the table. Descriptors below the split serve transmission and the rest, up to the last entry, serve reception. Software reads and writes the table through a 1 KB byte-addressed window.

The controller keeps a current transmit index and a current receive index. When software hands a transmit descriptor over, the controller issues a start request carrying that descriptor's length, buffer address and pad option to the datapath. When the datapath reports the end of the frame, it writes the completed descriptor back. When the datapath offers a received frame, the controller fills the current receive descriptor, or reports a busy event if software still holds that descriptor. Three event bits (transmit done, receive done, receive busy) are collected in a source register. Software clears them by writing ones. A mask gates them onto one interrupt line.

Top module: `bd_ring_ctrl`

## Requirements
- R1: Window byte address bits 9:2 select a table word and bits 1:0 are ignored. Entry e is word 2e (control: length in bits 31:16) and word 2e+1 (buffer address). Read data appears on the clock edge after the read request.
- R2: The split point resets to 64. A split write of 128 or more leaves it unchanged. rx_ready is high only while rx_enable is high, the split is below 128 and no accepted frame is still being processed.
- R3: A transmit request is issued only when tx_enable is high, the split is nonzero, the current transmit descriptor has its ready bit (bit 15) set and its length is greater than 4. The test is made after each window write and after each rising edge of tx_enable. The request carries the length, the buffer-address word and the pad bit (bit 12).
- R4: After a transmit completes, the transmit index becomes 0 if the descriptor's wrap bit (bit 13) was set. Otherwise it increments and becomes 0 when the result reaches the split.
- R5: On transmit completion the control word captured at start is written back with bits 15 and 8:0 cleared and all other bits kept. Source bit 0 is set if the descriptor's interrupt bit (bit 14) was set.
- R6: If the current receive descriptor's empty bit (bit 15) is clear when a frame is accepted, the table is not written, the receive index is unchanged and source bit 4 is set.
- R7: A frame accepted into an empty descriptor writes the frame length into bits 31:16, clears bits 15 and 8:0 and keeps the rest. Source bit 2 is set if bit 14 was set. The receive index moves to the split if the wrap bit (bit 13) was set or the index was 127, and increments otherwise.
- R8: A rising edge of rx_enable loads the receive index with the split. A rising edge of tx_enable loads the transmit index with 0.
- R9: Writing ones to the source-clear port clears those source bits. irq is high exactly when some source bit and its mask bit are both set.
- R10: After reset the transmit index is 0, the receive index is 64, the sources and mask are 0, irq is low and no request is pending.
- R11: A frame offered while rx_ready is low changes neither the table, the indices nor the sources.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| win_wr | input | 1 | Window write strobe |
| win_rd | input | 1 | Window read strobe |
| win_addr | input | 10 | Window byte address |
| win_wdata | input | 32 | Window write data |
| win_rdata | output | 32 | Window read data, one cycle after win_rd |
| tx_enable | input | 1 | Transmit enable level |
| rx_enable | input | 1 | Receive enable level |
| split_wr | input | 1 | Split point write strobe |
| split_wdata | input | 8 | New split point |
| split_q | output | 8 | Current split point |
| src_clr_wr | input | 1 | Source clear strobe |
| src_clr_data | input | 5 | Ones clear the matching source bits |
| mask_wr | input | 1 | Mask write strobe |
| mask_wdata | input | 5 | New interrupt mask |
| src_q | output | 5 | Event sources: bit 0 tx done, bit 2 rx done, bit 4 rx busy |
| irq | output | 1 | Interrupt line |
| txs_req | output | 1 | One-cycle transmit start request |
| txs_len | output | 16 | Frame length of the request |
| txs_ptr | output | 32 | Buffer address of the request |
| txs_pad | output | 1 | Pad option of the request |
| tx_done | input | 1 | Datapath pulse: transmission finished |
| rx_frame | input | 1 | Datapath pulse: a received frame is offered |
| rx_len | input | 16 | Length of the offered frame |
| rx_ready | output | 1 | A frame may be offered |
| tx_index | output | 7 | Current transmit descriptor |
| rx_index | output | 7 | Current receive descriptor |

## Verification
Directed cases separate length 4 from length 5, a wrap bit from an index that reaches the split, and index 127 from a plain increment. They also distinguish a busy descriptor from an empty one and a disabled receiver from an enabled one. A seeded random mix follows. It interleaves descriptor writes at and away from the current transmit index, completions, frames, split moves, enable toggles and mask or clear writes. Every port and every touched descriptor word is compared with a bench model. Random low flag bits show whether writeback clears exactly the status field and keeps the rest. Writes made while a frame is in flight show whether writeback uses the captured word rather than the table.

// File: rtl/bdr_pkg.sv
// Package: shared constants and state type of the descriptor ring controller.
// Assumes 32-bit table words with the length field in the upper half.
package bdr_pkg;
    localparam int LEN_LSB  = 16;
    localparam int LEN_W    = 16;
    localparam int BIT_OWN  = 15;   // tx: ready, rx: empty
    localparam int BIT_IRQ  = 14;
    localparam int BIT_WRAP = 13;
    localparam int BIT_PAD  = 12;
    // bits cleared when a descriptor is handed back to software
    localparam logic [31:0] DONE_CLR_MASK = 32'h0000_81FF;

    localparam int SRC_W    = 5;
    localparam int SRC_TXB  = 0;
    localparam int SRC_RXB  = 2;
    localparam int SRC_BUSY = 4;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_TX_RD,
        ST_TX_PTR,
        ST_TX_ISSUE,
        ST_TX_WB,
        ST_RX_RD,
        ST_RX_WB
    } eng_state_t;
endpackage

// File: rtl/bdr_table_ram.sv
// Module: two-port descriptor table. Port A serves the host window and
// port B serves the ring engine. Both ports read synchronously with one
// cycle of latency. Assumes the two ports never write the same word in
// the same cycle; if they do, port B wins.
module bdr_table_ram #(
    parameter int WORDS = 256,
    parameter int DW    = 32,
    localparam int AW   = $clog2(WORDS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          a_we,
    input  logic          a_re,
    input  logic [AW-1:0] a_addr,
    input  logic [DW-1:0] a_wdata,
    output logic [DW-1:0] a_rdata,
    input  logic          b_we,
    input  logic [AW-1:0] b_addr,
    input  logic [DW-1:0] b_wdata,
    output logic [DW-1:0] b_rdata
);
    logic [DW-1:0] mem [WORDS];

    // storage writes, engine port last so it takes precedence
    always_ff @(posedge clk) begin
        if (a_we) mem[a_addr] <= a_wdata;
        if (b_we) mem[b_addr] <= b_wdata;
    end

    // host read register, updated only on a read request
    always_ff @(posedge clk) begin
        if (!rst_n)    a_rdata <= '0;
        else if (a_re) a_rdata <= mem[a_addr];
    end

    // engine read register, follows its address every cycle
    always_ff @(posedge clk) begin
        if (!rst_n) b_rdata <= '0;
        else        b_rdata <= mem[b_addr];
    end
endmodule

// File: rtl/bdr_irq_ctrl.sv
// Module: event source register with write-one-to-clear and a mask.
// Assumes event pulses last one cycle. An event arriving in the same
// cycle as a clear of the same bit leaves the bit set.
module bdr_irq_ctrl #(
    parameter int SW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [SW-1:0] ev_set,
    input  logic          clr_wr,
    input  logic [SW-1:0] clr_data,
    input  logic          mask_wr,
    input  logic [SW-1:0] mask_data,
    output logic [SW-1:0] src_q,
    output logic          irq
);
    logic [SW-1:0] mask_q;
    logic [SW-1:0] clr_vec;

    assign clr_vec = clr_wr ? clr_data : '0;

    // source bits: clear by ones, then merge new events
    always_ff @(posedge clk) begin
        if (!rst_n) src_q <= '0;
        else        src_q <= (src_q & ~clr_vec) | ev_set;
    end

    // mask register
    always_ff @(posedge clk) begin
        if (!rst_n)       mask_q <= '0;
        else if (mask_wr) mask_q <= mask_data;
    end

    // interrupt line from the gated sources
    assign irq = |(src_q & mask_q);

    assert_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_wr && ev_set == '0) |=> ((src_q & $past(clr_data)) == '0));
    assert_mask_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_q == '0) |-> !irq);
endmodule

// File: rtl/bdr_ring_engine.sv
// Module: ring engine. Holds the split point and both current indices,
// runs the transmit start check, the transmit writeback and the receive
// writeback through one table port. Assumes tx_done pulses only after a
// request and that at most one received frame is outstanding.
module bdr_ring_engine
    import bdr_pkg::*;
#(
    parameter int ENTRIES   = 128,
    localparam int IDX_W    = $clog2(ENTRIES),
    localparam int SPLIT_W  = IDX_W + 1,
    localparam int AW       = IDX_W + 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tx_enable,
    input  logic               rx_enable,
    input  logic               split_wr,
    input  logic [SPLIT_W-1:0] split_wdata,
    input  logic               host_wr,
    output logic [AW-1:0]      b_addr,
    output logic               b_we,
    output logic [31:0]        b_wdata,
    input  logic [31:0]        b_rdata,
    output logic               txs_req,
    output logic [LEN_W-1:0]   txs_len,
    output logic [31:0]        txs_ptr,
    output logic               txs_pad,
    input  logic               tx_done,
    input  logic               rx_frame,
    input  logic [LEN_W-1:0]   rx_len,
    output logic               rx_ready,
    output logic [SRC_W-1:0]   ev_set,
    output logic [SPLIT_W-1:0] split_q,
    output logic [IDX_W-1:0]   tx_idx,
    output logic [IDX_W-1:0]   rx_idx
);
    localparam logic [SPLIT_W-1:0] SPLIT_LIM = SPLIT_W'(ENTRIES);
    localparam logic [SPLIT_W-1:0] SPLIT_RST = SPLIT_W'(ENTRIES / 2);
    localparam logic [IDX_W-1:0]   IDX_MAX   = IDX_W'(ENTRIES - 1);

    eng_state_t         state_q;
    logic [IDX_W-1:0]   tx_idx_q, rx_idx_q;
    logic [IDX_W-1:0]   tx_idx_nxt, rx_idx_nxt;
    logic [SPLIT_W-1:0] tx_inc;
    logic               tx_en_d, rx_en_d;
    logic               tx_rise, rx_rise;
    logic               tx_chk_q, tx_active_q, tx_done_pend_q, rx_pend_q;
    logic [LEN_W-1:0]   rx_len_q;
    logic [31:0]        txw_q;
    logic               tx_can_go;
    logic               rd_own;
    logic [LEN_W-1:0]   rd_len;

    assign tx_rise   = tx_enable && !tx_en_d;
    assign rx_rise   = rx_enable && !rx_en_d;
    assign tx_can_go = tx_enable && (split_q != '0) && !tx_active_q;
    assign rd_own    = b_rdata[BIT_OWN];
    assign rd_len    = b_rdata[LEN_LSB +: LEN_W];
    assign rx_ready  = rx_enable && (split_q < SPLIT_LIM) && !rx_pend_q;

    // next transmit index: wrap bit or reaching the split returns to 0
    assign tx_inc     = {1'b0, tx_idx_q} + SPLIT_W'(1);
    assign tx_idx_nxt = (txw_q[BIT_WRAP] || tx_inc >= split_q) ? '0 : tx_inc[IDX_W-1:0];
    // next receive index: wrap bit or last entry returns to the split
    assign rx_idx_nxt = (b_rdata[BIT_WRAP] || rx_idx_q == IDX_MAX) ?
                        split_q[IDX_W-1:0] : rx_idx_q + IDX_W'(1);

    // table port addressing, writeback data and event pulses per state
    always_comb begin
        b_addr  = '0;
        b_we    = 1'b0;
        b_wdata = '0;
        ev_set  = '0;
        case (state_q)
            ST_TX_RD:  b_addr = {tx_idx_q, 1'b0};
            ST_TX_PTR: b_addr = {tx_idx_q, 1'b1};
            ST_TX_WB: begin
                b_addr          = {tx_idx_q, 1'b0};
                b_we            = 1'b1;
                b_wdata         = txw_q & ~DONE_CLR_MASK;
                ev_set[SRC_TXB] = txw_q[BIT_IRQ];
            end
            ST_RX_RD:  b_addr = {rx_idx_q, 1'b0};
            ST_RX_WB: begin
                b_addr = {rx_idx_q, 1'b0};
                if (rd_own) begin
                    b_we            = 1'b1;
                    b_wdata         = {rx_len_q, b_rdata[15:0] & ~DONE_CLR_MASK[15:0]};
                    ev_set[SRC_RXB] = b_rdata[BIT_IRQ];
                end else begin
                    ev_set[SRC_BUSY] = 1'b1;
                end
            end
            default: ;
        endcase
    end

    // control state, indices, split point and request registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q        <= ST_IDLE;
            tx_idx_q       <= '0;
            rx_idx_q       <= SPLIT_RST[IDX_W-1:0];
            split_q        <= SPLIT_RST;
            tx_en_d        <= 1'b0;
            rx_en_d        <= 1'b0;
            tx_chk_q       <= 1'b0;
            tx_active_q    <= 1'b0;
            tx_done_pend_q <= 1'b0;
            rx_pend_q      <= 1'b0;
            rx_len_q       <= '0;
            txw_q          <= '0;
            txs_req        <= 1'b0;
            txs_len        <= '0;
            txs_ptr        <= '0;
            txs_pad        <= 1'b0;
        end else begin
            tx_en_d <= tx_enable;
            rx_en_d <= rx_enable;
            txs_req <= 1'b0;
            if (split_wr && split_wdata < SPLIT_LIM) split_q <= split_wdata;
            if (host_wr) tx_chk_q <= 1'b1;
            if (tx_done && tx_active_q) tx_done_pend_q <= 1'b1;
            if (rx_frame && rx_ready) begin
                rx_pend_q <= 1'b1;
                rx_len_q  <= rx_len;
            end
            case (state_q)
                ST_IDLE: begin
                    if (tx_done_pend_q) begin
                        state_q <= ST_TX_WB;
                    end else if (rx_pend_q) begin
                        state_q <= ST_RX_RD;
                    end else if (tx_chk_q) begin
                        tx_chk_q <= 1'b0;
                        if (tx_can_go) state_q <= ST_TX_RD;
                    end
                end
                ST_TX_RD: state_q <= ST_TX_PTR;
                ST_TX_PTR: begin
                    txw_q   <= b_rdata;
                    state_q <= (rd_own && rd_len > LEN_W'(4)) ? ST_TX_ISSUE : ST_IDLE;
                end
                ST_TX_ISSUE: begin
                    txs_req     <= 1'b1;
                    txs_len     <= txw_q[LEN_LSB +: LEN_W];
                    txs_pad     <= txw_q[BIT_PAD];
                    txs_ptr     <= b_rdata;
                    tx_active_q <= 1'b1;
                    state_q     <= ST_IDLE;
                end
                ST_TX_WB: begin
                    tx_idx_q       <= tx_idx_nxt;
                    tx_active_q    <= 1'b0;
                    tx_done_pend_q <= 1'b0;
                    state_q        <= ST_IDLE;
                end
                ST_RX_RD: state_q <= ST_RX_WB;
                ST_RX_WB: begin
                    if (rd_own) rx_idx_q <= rx_idx_nxt;
                    rx_pend_q <= 1'b0;
                    state_q   <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
            if (tx_rise) begin
                tx_idx_q <= '0;
                tx_chk_q <= 1'b1;
            end
            if (rx_rise) rx_idx_q <= split_q[IDX_W-1:0];
        end
    end

    assign tx_idx = tx_idx_q;
    assign rx_idx = rx_idx_q;

    assert_split_ignore_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (split_wr && split_wdata >= SPLIT_LIM) |=> (split_q == $past(split_q)));
    assert_start_cond_R3: assert property (@(posedge clk) disable iff (!rst_n)
        txs_req |-> (txs_len > LEN_W'(4) && split_q != '0));
    assert_req_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
        txs_req |=> !txs_req);
    assert_tx_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_TX_WB && txw_q[BIT_WRAP]) |=> (tx_idx_q == '0));
    assert_busy_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RX_WB && !rd_own && !rx_rise) |=> $stable(rx_idx_q));
    assert_rx_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RX_WB && rd_own && (b_rdata[BIT_WRAP] || rx_idx_q == IDX_MAX) && !rx_rise)
        |=> (rx_idx_q == $past(split_q[IDX_W-1:0])));
    assert_tx_reload_R8: assert property (@(posedge clk) disable iff (!rst_n)
        tx_rise |=> (tx_idx_q == '0));
endmodule

// File: rtl/bd_ring_ctrl.sv
// Module: top of the descriptor ring controller. Joins the table, the
// ring engine and the event register, and maps the byte-addressed host
// window onto table words. Assumes word-wide window accesses only.
module bd_ring_ctrl
    import bdr_pkg::*;
#(
    parameter int ENTRIES  = 128,
    localparam int IDX_W   = $clog2(ENTRIES),
    localparam int SPLIT_W = IDX_W + 1,
    localparam int WAW     = IDX_W + 1,
    localparam int WIN_W   = WAW + 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               win_wr,
    input  logic               win_rd,
    input  logic [WIN_W-1:0]   win_addr,
    input  logic [31:0]        win_wdata,
    output logic [31:0]        win_rdata,
    input  logic               tx_enable,
    input  logic               rx_enable,
    input  logic               split_wr,
    input  logic [SPLIT_W-1:0] split_wdata,
    output logic [SPLIT_W-1:0] split_q,
    input  logic               src_clr_wr,
    input  logic [SRC_W-1:0]   src_clr_data,
    input  logic               mask_wr,
    input  logic [SRC_W-1:0]   mask_wdata,
    output logic [SRC_W-1:0]   src_q,
    output logic               irq,
    output logic               txs_req,
    output logic [LEN_W-1:0]   txs_len,
    output logic [31:0]        txs_ptr,
    output logic               txs_pad,
    input  logic               tx_done,
    input  logic               rx_frame,
    input  logic [LEN_W-1:0]   rx_len,
    output logic               rx_ready,
    output logic [IDX_W-1:0]   tx_index,
    output logic [IDX_W-1:0]   rx_index
);
    logic [WAW-1:0]   b_addr;
    logic             b_we;
    logic [31:0]      b_wdata, b_rdata;
    logic [SRC_W-1:0] ev_set;
    logic             addr_lo_unused;

    // byte lanes are not supported: the two low address bits are dropped
    assign addr_lo_unused = ^win_addr[1:0];

    bdr_table_ram #(.WORDS(2 * ENTRIES), .DW(32)) u_table (
        .clk     (clk),
        .rst_n   (rst_n),
        .a_we    (win_wr),
        .a_re    (win_rd),
        .a_addr  (win_addr[WIN_W-1:2]),
        .a_wdata (win_wdata),
        .a_rdata (win_rdata),
        .b_we    (b_we),
        .b_addr  (b_addr),
        .b_wdata (b_wdata),
        .b_rdata (b_rdata)
    );

    bdr_ring_engine #(.ENTRIES(ENTRIES)) u_engine (
        .clk         (clk),
        .rst_n       (rst_n),
        .tx_enable   (tx_enable),
        .rx_enable   (rx_enable),
        .split_wr    (split_wr),
        .split_wdata (split_wdata),
        .host_wr     (win_wr),
        .b_addr      (b_addr),
        .b_we        (b_we),
        .b_wdata     (b_wdata),
        .b_rdata     (b_rdata),
        .txs_req     (txs_req),
        .txs_len     (txs_len),
        .txs_ptr     (txs_ptr),
        .txs_pad     (txs_pad),
        .tx_done     (tx_done),
        .rx_frame    (rx_frame),
        .rx_len      (rx_len),
        .rx_ready    (rx_ready),
        .ev_set      (ev_set),
        .split_q     (split_q),
        .tx_idx      (tx_index),
        .rx_idx      (rx_index)
    );

    bdr_irq_ctrl #(.SW(SRC_W)) u_irq (
        .clk       (clk),
        .rst_n     (rst_n),
        .ev_set    (ev_set),
        .clr_wr    (src_clr_wr),
        .clr_data  (src_clr_data),
        .mask_wr   (mask_wr),
        .mask_data (mask_wdata),
        .src_q     (src_q),
        .irq       (irq)
    );
endmodule

// File: tb/bd_ring_ctrl_tb.sv
// Bench: directed corner cases followed by a seeded random mix, all
// compared against a behavioural model of the requirements.
module bd_ring_ctrl_tb_top;
    localparam int ENTRIES = 128;
    localparam int WORDS   = 256;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        win_wr = 1'b0, win_rd = 1'b0;
    logic [9:0]  win_addr = '0;
    logic [31:0] win_wdata = '0;
    logic [31:0] win_rdata;
    logic        tx_enable = 1'b0, rx_enable = 1'b0;
    logic        split_wr = 1'b0;
    logic [7:0]  split_wdata = '0;
    logic [7:0]  split_q;
    logic        src_clr_wr = 1'b0;
    logic [4:0]  src_clr_data = '0;
    logic        mask_wr = 1'b0;
    logic [4:0]  mask_wdata = '0;
    logic [4:0]  src_q;
    logic        irq;
    logic        txs_req;
    logic [15:0] txs_len;
    logic [31:0] txs_ptr;
    logic        txs_pad;
    logic        tx_done = 1'b0;
    logic        rx_frame = 1'b0;
    logic [15:0] rx_len = '0;
    logic        rx_ready;
    logic [6:0]  tx_index, rx_index;

    always #5 clk = ~clk;

    bd_ring_ctrl #(.ENTRIES(ENTRIES)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .win_wr(win_wr), .win_rd(win_rd), .win_addr(win_addr),
        .win_wdata(win_wdata), .win_rdata(win_rdata),
        .tx_enable(tx_enable), .rx_enable(rx_enable),
        .split_wr(split_wr), .split_wdata(split_wdata), .split_q(split_q),
        .src_clr_wr(src_clr_wr), .src_clr_data(src_clr_data),
        .mask_wr(mask_wr), .mask_wdata(mask_wdata),
        .src_q(src_q), .irq(irq),
        .txs_req(txs_req), .txs_len(txs_len), .txs_ptr(txs_ptr), .txs_pad(txs_pad),
        .tx_done(tx_done), .rx_frame(rx_frame), .rx_len(rx_len), .rx_ready(rx_ready),
        .tx_index(tx_index), .rx_index(rx_index)
    );

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    // model state
    logic [31:0] m_mem [WORDS];
    int          m_txi, m_rxi, m_split;
    bit          m_txen, m_rxen, m_active;
    logic [31:0] m_txw;
    logic [4:0]  m_src, m_mask;
    int          m_reqs;
    logic [15:0] m_len;
    logic [31:0] m_ptr;
    logic        m_pad;

    // observed requests
    int          req_seen = 0;
    logic [15:0] got_len = '0;
    logic [31:0] got_ptr = '0;
    logic        got_pad = 1'b0;

    always @(negedge clk) begin
        if (rst_n && txs_req) begin
            req_seen++;
            got_len = txs_len;
            got_ptr = txs_ptr;
            got_pad = txs_pad;
        end
    end

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic int f_tx_next(int idx, bit wrap, int split);
        int n = idx + 1;
        if (wrap || n >= split) return 0;
        return n;
    endfunction

    function automatic int f_rx_next(int idx, bit wrap, int split);
        if (wrap || idx == ENTRIES - 1) return split;
        return idx + 1;
    endfunction

    function automatic logic [31:0] f_tx_wb(logic [31:0] w);
        return w & ~32'h0000_81FF;
    endfunction

    function automatic logic [31:0] f_rx_wb(logic [31:0] w, logic [15:0] len);
        return {len, w[15:0] & ~16'h81FF};
    endfunction

    task automatic model_tx_check();
        logic [31:0] w;
        w = m_mem[2 * m_txi];
        if (m_txen && m_split != 0 && !m_active && w[15] && w[31:16] > 16'd4) begin
            m_active = 1;
            m_txw    = w;
            m_reqs++;
            m_len    = w[31:16];
            m_ptr    = m_mem[2 * m_txi + 1];
            m_pad    = w[12];
        end
    endtask

    task automatic settle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic win_write(int w, logic [31:0] d, logic [1:0] lo, int wait_n);
        @(negedge clk);
        win_wr = 1'b1; win_addr = {w[7:0], lo}; win_wdata = d;
        @(negedge clk);
        win_wr = 1'b0;
        m_mem[w] = d;
        model_tx_check();
        settle(wait_n);
    endtask

    task automatic win_read(int w, logic [1:0] lo, output logic [31:0] d);
        @(negedge clk);
        win_rd = 1'b1; win_addr = {w[7:0], lo};
        @(negedge clk);
        win_rd = 1'b0;
        d = win_rdata;
    endtask

    task automatic check_word(string req, int w);
        logic [31:0] d;
        win_read(w, 2'b00, d);
        chk(req, $sformatf("word%0d", w), 64'(d), 64'(m_mem[w]));
    endtask

    task automatic check_state(string req);
        chk(req, "tx_index", 64'(tx_index), 64'(m_txi));
        chk(req, "rx_index", 64'(rx_index), 64'(m_rxi));
        chk(req, "src_q",    64'(src_q),    64'(m_src));
        chk(req, "irq",      64'(irq),      64'(|(m_src & m_mask)));
        chk(req, "split_q",  64'(split_q),  64'(m_split));
        chk(req, "req_count", 64'(req_seen), 64'(m_reqs));
        if (m_reqs > 0) begin
            chk(req, "txs_len", 64'(got_len), 64'(m_len));
            chk(req, "txs_ptr", 64'(got_ptr), 64'(m_ptr));
            chk(req, "txs_pad", 64'(got_pad), 64'(m_pad));
        end
    endtask

    task automatic set_txen(bit v);
        @(negedge clk);
        tx_enable = v;
        if (v && !m_txen) begin
            m_txen = 1; m_txi = 0;
            model_tx_check();
        end
        m_txen = v;
        settle(8);
    endtask

    task automatic set_rxen(bit v);
        @(negedge clk);
        rx_enable = v;
        if (v && !m_rxen) m_rxi = m_split;
        m_rxen = v;
        settle(4);
    endtask

    task automatic write_split(int v);
        @(negedge clk);
        split_wr = 1'b1; split_wdata = v[7:0];
        @(negedge clk);
        split_wr = 1'b0;
        if (v < ENTRIES) m_split = v;
        settle(2);
    endtask

    task automatic pulse_done();
        @(negedge clk);
        tx_done = 1'b1;
        @(negedge clk);
        tx_done = 1'b0;
        if (m_active) begin
            m_mem[2 * m_txi] = f_tx_wb(m_txw);
            if (m_txw[14]) m_src[0] = 1'b1;
            m_txi = f_tx_next(m_txi, m_txw[13], m_split);
            m_active = 0;
        end
        settle(8);
    endtask

    task automatic offer_frame(logic [15:0] len);
        bit exp_ready;
        logic [31:0] w;
        exp_ready = m_rxen && m_split < ENTRIES;
        chk("R2", "rx_ready", 64'(rx_ready), 64'(exp_ready));
        @(negedge clk);
        rx_frame = 1'b1; rx_len = len;
        @(negedge clk);
        rx_frame = 1'b0;
        if (exp_ready) begin
            w = m_mem[2 * m_rxi];
            if (w[15]) begin
                m_mem[2 * m_rxi] = f_rx_wb(w, len);
                if (w[14]) m_src[2] = 1'b1;
                m_rxi = f_rx_next(m_rxi, w[13], m_split);
            end else begin
                m_src[4] = 1'b1;
            end
        end
        settle(8);
    endtask

    task automatic clear_src(logic [4:0] v);
        @(negedge clk);
        src_clr_wr = 1'b1; src_clr_data = v;
        @(negedge clk);
        src_clr_wr = 1'b0;
        m_src = m_src & ~v;
        settle(1);
    endtask

    task automatic write_mask(logic [4:0] v);
        @(negedge clk);
        mask_wr = 1'b1; mask_wdata = v;
        @(negedge clk);
        mask_wr = 1'b0;
        m_mask = v;
        settle(1);
    endtask

    task automatic tx_desc(int idx, logic [15:0] len, logic [15:0] flags, logic [31:0] ptr);
        win_write(2 * idx + 1, ptr, 2'b00, 6);
        win_write(2 * idx, {len, flags}, 2'b00, 8);
    endtask

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            fails++;
            checks++;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        int prev;
        void'($urandom(32'd20240611));
        m_txi = 0; m_rxi = 64; m_split = 64;
        m_txen = 0; m_rxen = 0; m_active = 0;
        m_txw = '0; m_src = '0; m_mask = '0; m_reqs = 0;
        m_len = '0; m_ptr = '0; m_pad = 1'b0;

        settle(4);
        @(negedge clk);
        rst_n = 1'b1;
        settle(2);
        // R10: reset state
        check_state("R10");
        chk("R10", "txs_req", 64'(txs_req), 64'd0);
        chk("R2", "rx_ready_disabled", 64'(rx_ready), 64'd0);

        // R1: window mapping, low address bits ignored, read latency
        win_write(5, 32'hA5A5_1234, 2'b11, 1);
        win_read(5, 2'b00, d);
        chk("R1", "low_bits_ignored", 64'(d), 64'h A5A5_1234);
        win_read(5, 2'b10, d);
        chk("R1", "readback", 64'(d), 64'h A5A5_1234);

        // initialise the whole table
        for (int w = 0; w < WORDS; w++) begin
            if (w % 2 == 1)        win_write(w, 32'h1000_0000 + w, 2'b00, 1);
            else if (w / 2 < 64)   win_write(w, 32'h0000_0000, 2'b00, 1);
            else                   win_write(w, 32'h0000_C000, 2'b00, 1);
        end
        settle(4);

        // R2: split write out of range ignored, in range accepted
        write_split(200);
        chk("R2", "split_ignored", 64'(split_q), 64'd64);
        write_split(8);
        chk("R2", "split_taken", 64'(split_q), 64'd8);

        // R8 / R3: enable transmit, length 4 must not start
        set_txen(1);
        check_state("R8");
        tx_desc(0, 16'd4, 16'hC000, 32'h0000_4000);
        check_state("R3");
        chk("R3", "len4_no_req", 64'(req_seen), 64'd0);
        // length 5 starts, pad carried
        tx_desc(0, 16'd5, 16'hD0F3, 32'h0000_4400);
        chk("R3", "len5_req", 64'(req_seen), 64'd1);
        check_state("R3");
        // R5: completion writeback and event
        pulse_done();
        check_word("R5", 0);
        chk("R5", "wb_value", 64'(m_mem[0]), 64'h0005_5000);
        check_state("R5");
        write_mask(5'h01);
        check_state("R9");
        chk("R9", "irq_on", 64'(irq), 64'd1);
        clear_src(5'h01);
        check_state("R9");
        chk("R9", "irq_off", 64'(irq), 64'd0);

        // R4: wrap bit returns to 0
        tx_desc(1, 16'd60, 16'hA000, 32'h0000_5000);
        pulse_done();
        check_state("R4");
        chk("R4", "wrap_to_zero", 64'(tx_index), 64'd0);
        // R4: walk to the split
        for (int i = 0; i < 8; i++) begin
            tx_desc(i, 16'd64 + 16'(i), 16'h8000, 32'h0000_6000 + 32'(i));
            pulse_done();
            check_state("R4");
        end
        chk("R4", "split_to_zero", 64'(tx_index), 64'd0);

        // R11: frame with receive disabled is ignored
        offer_frame(16'd77);
        check_state("R11");
        check_word("R11", 2 * 8);

        // R8 / R7: enable receive
        set_rxen(1);
        chk("R8", "rx_reload", 64'(rx_index), 64'd8);
        win_write(16, 32'h0000_C0FF, 2'b00, 2);
        offer_frame(16'd60);
        check_word("R7", 16);
        chk("R7", "rx_wb_value", 64'(m_mem[16]), 64'h003C_4000);
        check_state("R7");
        // R6: busy descriptor
        win_write(18, 32'h0000_4000, 2'b00, 2);
        offer_frame(16'd90);
        check_word("R6", 18);
        check_state("R6");
        chk("R6", "busy_bit", 64'(src_q[4]), 64'd1);
        // R7: wrap bit returns to split
        win_write(18, 32'h0000_E000, 2'b00, 2);
        offer_frame(16'd100);
        check_state("R7");
        chk("R7", "rx_wrap", 64'(rx_index), 64'd8);
        // R7: index 127 returns to split
        write_split(120);
        set_rxen(0);
        set_rxen(1);
        chk("R8", "rx_reload_120", 64'(rx_index), 64'd120);
        for (int i = 120; i < 128; i++) win_write(2 * i, 32'h0000_8000, 2'b00, 1);
        for (int i = 0; i < 8; i++) begin
            offer_frame(16'd200 + 16'(i));
            check_state("R7");
        end
        chk("R7", "last_entry_wrap", 64'(rx_index), 64'd120);
        clear_src(5'h1F);
        check_state("R9");

        // random mix
        for (int it = 0; it < 300; it++) begin
            int op;
            op = $urandom_range(0, 9);
            if (op <= 2) begin
                int idx;
                logic [15:0] fl;
                idx = ($urandom_range(0, 1) == 1 || m_split == 0) ? m_txi :
                      $urandom_range(0, m_split - 1);
                fl = 16'($urandom) & 16'h7FFF;
                if ($urandom_range(0, 3) != 0) fl[15] = 1'b1;
                fl[13] = ($urandom_range(0, 5) == 0);
                tx_desc(idx, 16'($urandom_range(0, 24)), fl, $urandom);
                check_state("R3");
            end else if (op == 3) begin
                prev = m_txi;
                pulse_done();
                check_word("R5", 2 * prev);
                check_state("R4");
            end else if (op <= 5) begin
                int idx;
                logic [15:0] fl;
                idx = ($urandom_range(0, 1) == 1) ? m_rxi :
                      $urandom_range(m_split < ENTRIES ? m_split : 0, ENTRIES - 1);
                fl = 16'($urandom) & 16'h5FFF;
                if ($urandom_range(0, 3) != 0) fl[15] = 1'b1;
                fl[13] = ($urandom_range(0, 7) == 0);
                win_write(2 * idx, {16'($urandom), fl}, 2'b00, 8);
                check_state("R3");
            end else if (op <= 7) begin
                prev = m_rxi;
                offer_frame(16'($urandom_range(1, 1518)));
                check_word("R7", 2 * prev);
                check_state("R7");
            end else if (op == 8) begin
                write_mask(5'($urandom));
                clear_src(5'($urandom));
                check_state("R9");
            end else begin
                case ($urandom_range(0, 3))
                    0: write_split($urandom_range(0, 255));
                    1: set_txen(!m_txen);
                    2: set_rxen(!m_rxen);
                    default: begin
                        set_txen(0);
                        set_txen(1);
                    end
                endcase
                check_state("R8");
            end
        end

        finished = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule